// File: doc/BRIEF.md
# Bit-Serial by Parallel Signed Multiplier

This block multiplies a two's-complement word held in parallel form by a second two's-complement word that arrives one bit per clock, least significant bit first. The product leaves on a single wire, also least significant bit first. Internally the block is a row of identical cells, one for each bit of the parallel operand. Each cell has a one-bit full adder, a sum flip-flop and a carry flip-flop. The only signals that run the length of the row are the neighbour-to-neighbour sum links and the serial bit, which reaches every cell at the same time. The cell that holds the parallel sign bit subtracts its partial product instead of adding it, so signed operands produce a correct two's-complement result without any correction step.

Software or an upstream engine first loads the parallel operand. It then opens a frame with a start flag on the cycle that carries the first serial bit, and supplies the remaining serial bits on the following cycles. Once the serial word is complete, the block keeps repeating its last bit (the sign) internally, so the whole product of serial width plus parallel width bits comes out with no overflow. A new frame can follow the previous one with no idle cycle between them.

Top module: `smul_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `prod_valid` and `prod_bit` are both 0.
- R2: A cycle with `par_load` high stores `par_in` as the parallel operand. Every frame that starts later uses that value until the next load.
- R3: The cycle with `ser_start` high carries serial bit 0. Serial bit k is taken k cycles later. Product bit k appears on `prod_bit` in the cycle after serial bit k was taken.
- R4: After a start, `prod_valid` is high for exactly SW+PW consecutive cycles. The bits shown during that window are the SW+PW-bit two's-complement product of the signed parallel operand and the signed serial word.
- R5: Frame positions SW through SW+PW-1 ignore `ser_bit`. The block uses the serial bit taken at position SW-1 (the sign) in their place.
- R6: A start clears every cell's sum and carry state, so frames that follow each other with no gap give products that are each correct on their own.
- R7: Corner operands give exact results, including the most negative value on either side or on both sides, zero, and -1.
- R8: A `ser_start` that arrives while a frame is still running drops that frame. A full new window of SW+PW valid cycles begins from the new start.
- R9: When no frame is running, `prod_valid` stays 0, `prod_bit` keeps its last value, and `ser_bit` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | PW | Parallel operand, two's complement |
| par_load | input | 1 | Stores `par_in` as the parallel operand |
| ser_bit | input | 1 | Serial operand bit, least significant first |
| ser_start | input | 1 | Marks the first serial bit of a frame |
| prod_bit | output | 1 | Serial product bit, least significant first |
| prod_valid | output | 1 | High while `prod_bit` carries a product bit |

## Verification
The checker assumes that reset is held for at least one clock. It also assumes that a frame begins only on a `ser_start` cycle, so its own countdown, started by the same flag, can stand for the frame window. The block's result is correct only if `par_load` is never raised while a frame runs. No property covers that rule; the stimulus keeps to it by loading operands only in the cycle after a frame's last serial bit, or in idle gaps. The stimulus covers several cases: frames placed back to back, a restart in the middle of a frame, random noise on `ser_bit` during the extension positions, and idle stretches. The reference model follows every one of these cycle by cycle.

// File: rtl/smul_pkg.sv
package smul_pkg;

    // result of a one-bit full adder
    typedef struct packed {
        logic carry;
        logic sum;
    } fa_t;

    // per-cycle control word sent to every cell
    typedef struct packed {
        logic step;     // the row advances this cycle
        logic first;    // first bit of a frame: discard old state
        logic bit_eff;  // serial bit after sign extension
    } slot_t;

    function automatic fa_t full_add(input logic x, input logic y, input logic z);
        fa_t r;
        r.sum   = x ^ y ^ z;
        r.carry = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

endpackage

// File: rtl/smul_seq.sv
module smul_seq
    import smul_pkg::*;
#(
    parameter int SW = 8,
    parameter int PW = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ser_start,
    input  logic  ser_bit,
    output slot_t ctl
);
    localparam int L  = SW + PW;
    localparam int CW = $clog2(L + 1);

    logic [CW-1:0] cnt_q;
    logic          active_q;
    logic          sign_q;
    logic [CW-1:0] pos;
    logic [CW-1:0] pos_nxt;

    always_comb begin
        pos         = ser_start ? '0 : cnt_q;
        pos_nxt     = pos + CW'(1);
        ctl.step    = ser_start | active_q;
        ctl.first   = ser_start;
        ctl.bit_eff = (pos < CW'(SW)) ? ser_bit : sign_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
            sign_q   <= 1'b0;
        end else if (ctl.step) begin
            cnt_q    <= pos_nxt;
            active_q <= (pos_nxt < CW'(L));
            if (pos == CW'(SW - 1))
                sign_q <= ser_bit;
        end
    end

endmodule

// File: rtl/smul_cell.sv
module smul_cell
    import smul_pkg::*;
#(
    parameter bit NEG = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  slot_t ctl,
    input  logic  a_bit,
    input  logic  nbr_in,
    output logic  sum_q
);
    logic carry_q;
    logic pp;
    logic c_in;
    logic n_in;
    fa_t  r;

    always_comb begin
        // the sign cell adds the inverted partial product with carry preset to 1
        pp   = (a_bit & ctl.bit_eff) ^ NEG;
        c_in = ctl.first ? NEG : carry_q;
        n_in = ctl.first ? 1'b0 : nbr_in;
        r    = full_add(pp, n_in, c_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q   <= 1'b0;
            carry_q <= 1'b0;
        end else if (ctl.step) begin
            sum_q   <= r.sum;
            carry_q <= r.carry;
        end
    end

endmodule

// File: rtl/smul_top.sv
module smul_top
    import smul_pkg::*;
#(
    parameter int PW = 8,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] par_in,
    input  logic          par_load,
    input  logic          ser_bit,
    input  logic          ser_start,
    output logic          prod_bit,
    output logic          prod_valid
);
    logic [PW-1:0] a_q;
    logic [PW:0]   link;
    slot_t         ctl;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q        <= '0;
            prod_valid <= 1'b0;
        end else begin
            if (par_load)
                a_q <= par_in;
            prod_valid <= ctl.step;
        end
    end

    smul_seq #(.SW(SW), .PW(PW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ser_start (ser_start),
        .ser_bit   (ser_bit),
        .ctl       (ctl)
    );

    assign link[PW] = 1'b0;

    for (genvar i = 0; i < PW; i++) begin : g_cell
        smul_cell #(.NEG(i == PW - 1)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl),
            .a_bit  (a_q[i]),
            .nbr_in (link[i+1]),
            .sum_q  (link[i])
        );
    end

    assign prod_bit = link[0];

endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
    parameter int PW = 8,
    parameter int SW = 8
) (
    input logic clk,
    input logic rst,
    input logic ser_start,
    input logic prod_valid,
    input logic prod_bit
);
    localparam int L  = SW + PW;
    localparam int CW = $clog2(L + 1);

    // cycles of product still owed by the current frame
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (ser_start)
            left_q <= CW'(L);
        else if (left_q != '0)
            left_q <= left_q - CW'(1);
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!prod_valid && !prod_bit));

    p_valid_window_r4: assert property (@(posedge clk) disable iff (rst)
        prod_valid == (left_q != '0));

    p_restart_valid_r8: assert property (@(posedge clk) disable iff (rst)
        ser_start |=> prod_valid);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (left_q == '0 && !ser_start) |=> (!prod_valid && $stable(prod_bit)));

endmodule

bind smul_top smul_chk #(.PW(PW), .SW(SW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ser_start  (ser_start),
    .prod_valid (prod_valid),
    .prod_bit   (prod_bit)
);

// File: tb/test_smul_top.sv
`timescale 1ns/1ps
module test_smul_top;
    localparam int PW = 8;
    localparam int SW = 8;
    localparam int L  = SW + PW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] par_in = '0;
    logic          par_load = 1'b0;
    logic          ser_bit = 1'b0;
    logic          ser_start = 1'b0;
    logic          prod_bit;
    logic          prod_valid;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    exp_q[$];
    string tag_q[$];
    bit    last_out = 1'b0;
    string idle_tag = "R1";
    logic [PW-1:0] a_model = '0;

    always #2 clk = ~clk;

    smul_top #(.PW(PW), .SW(SW)) i_smul_top (
        .clk(clk), .rst(rst), .par_in(par_in), .par_load(par_load),
        .ser_bit(ser_bit), .ser_start(ser_start),
        .prod_bit(prod_bit), .prod_valid(prod_valid)
    );

    task automatic check_out();
        n_tests++;
        if (exp_q.size() > 0) begin
            bit    e = exp_q.pop_front();
            string t = tag_q.pop_front();
            if (prod_valid !== 1'b1 || prod_bit !== e) begin
                n_fail++;
                $display("FAIL %s: valid/bit actual %b/%b expected 1/%b", t, prod_valid, prod_bit, e);
            end
            last_out = e;
        end else if (prod_valid !== 1'b0 || prod_bit !== last_out) begin
            n_fail++;
            $display("FAIL %s: idle valid/bit actual %b/%b expected 0/%b", idle_tag, prod_valid, prod_bit, last_out);
        end
    endtask

    task automatic step(input bit st, input bit b, input bit ld, input logic [PW-1:0] av);
        @(negedge clk);
        check_out();
        ser_start = st;
        ser_bit   = b;
        par_load  = ld;
        par_in    = av;
    endtask

    task automatic load(input logic [PW-1:0] av);   // R2
        step(1'b0, 1'($urandom), 1'b1, av);
        a_model = av;
    endtask

    // nbits < L gives a frame that a later start abandons (R8)
    task automatic frame(input logic [SW-1:0] b, input bit noise, input int nbits, input string tag);
        for (int k = 0; k < nbits; k++) begin
            bit sb = (k < SW) ? b[k] : (noise ? 1'($urandom) : 1'b0);
            step(k == 0, sb, 1'b0, '0);
            if (k == 0) begin
                longint p = longint'($signed(a_model)) * longint'($signed(b));
                exp_q.delete();
                tag_q.delete();
                for (int j = 0; j < L; j++) begin
                    exp_q.push_back(p[j]);
                    tag_q.push_back(tag);
                end
            end
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++)
            step(1'b0, 1'($urandom), 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        idle(2);                              // R1 reset state
        @(negedge clk);
        rst = 1'b0;
        idle(2);                              // R1 first cycles after reset
        idle_tag = "R9";
        load(8'd3);
        frame(8'd5, 1'b0, L, "R3");
        idle(3);                              // R9 idle, ser_bit toggling
        load(8'd200);
        frame(8'd77, 1'b0, L, "R4");
        frame(-8'sd9, 1'b1, L, "R5");         // noise during extension
        frame(8'd127, 1'b1, L, "R6");         // back to back
        load(8'h80);
        frame(8'h80, 1'b0, L, "R7");          // -128 * -128
        frame(8'hFF, 1'b0, L, "R7");          // -128 * -1
        frame(8'd127, 1'b0, L, "R7");
        load(8'd0);
        frame(8'h80, 1'b1, L, "R7");
        load(8'd127);                         // R2 new operand
        frame(8'h80, 1'b0, L, "R2");
        frame(8'd100, 1'b0, 5, "R8");         // abandoned
        frame(8'hC3, 1'b1, L, "R8");
        idle(4);
        for (int r = 0; r < 20; r++) begin
            load(8'($urandom));
            frame(8'($urandom), 1'b1, L, "R4");
            if (r % 3 == 0) idle(r % 5);
        end
        idle(3);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule